// File: doc/BRIEF.md
# Dual-Clock Word Stream FIFO with Sideband Flag

This block is a one-way, point-to-point queue that moves words from a single producer to a single consumer, such as a processor feeding an accelerator in the fabric. No other agent shares the channel, so there is no arbitration and no addressing. Each stored entry pairs a data word with one sideband flag bit. The producer can use that bit to mark headers or the last word of a packet, and the bit always leaves the queue together with its own word.

The producer side has its own clock and reset. It offers a word, a flag bit and a write strobe, and it sees a `full` indication. The consumer side also has its own clock and reset. It sees the oldest stored word and its flag together with an `exists` indication, and it pulses a read strobe to pop that word (first-word fall-through). The parameter `ASYNC` selects the variant:
- `ASYNC=1`: the two clocks are unrelated. Pointers cross between them as Gray code through a chain of synchronizer flops. Both flags can therefore lag, but they always lag toward the safe side.
- `ASYNC=0`: both clock pins must carry the same clock. Pointers are compared directly, and the flags change in the cycle after the event that moves them.

Top module: `stream_link_fifo`

## Requirements
- R1: Every accepted word leaves the queue in write order, and each word comes out with the same `wr_ctrl` bit that was written with it (`rd_ctrl` is bit 32 of the entry, `rd_data` is bits 31:0).
- R2: `exists` is never high while the queue holds no entries.
- R3: While `exists` is high, `rd_data` and `rd_ctrl` show the oldest stored entry. These outputs stay unchanged until that entry is read.
- R4: After `DEPTH` accepted writes with no reads, `full` is high.
- R5: A write strobe raised while `full` is high is ignored. No entry is added, and the stored contents are unchanged.
- R6: A read strobe raised while `exists` is low is ignored. No pointer moves, and the next word written is the next word read.
- R7: In the asynchronous variant, each registered Gray pointer changes by at most one bit per clock. No write is ever accepted while the queue already holds `DEPTH` entries.
- R8: After either reset has been asserted and released, `full` is low and `exists` is low.
- R9: A read and a write in the same cycle, with exactly one entry stored, neither lose nor duplicate a word.
- R10: In the synchronous variant, `exists` is high and the written word is visible in the first cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer reset, active low, asynchronous |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to store |
| wr_ctrl | input | 1 | Sideband flag stored with the word |
| full | output | 1 | High when no further write can be taken |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer reset, active low, asynchronous |
| rd_en | input | 1 | Read strobe, pops the oldest entry |
| rd_data | output | DATA_W | Oldest stored word |
| rd_ctrl | output | 1 | Sideband flag of the oldest word |
| exists | output | 1 | High when an entry can be read |

## Verification
A pointer that advanced twice, or one that failed to advance, shows up at the consumer as a skipped or repeated word. A flag bit that slips out of step with its data shows up as a word carrying the wrong marker. Both are caught on the read that follows, at the latest once the synchronizer stages have passed the pointer across. A bad full or empty comparison shows up as an overflowed word or a read of an entry that was never written. The bench catches that on the very cycle the producer's offer is accepted, or when a read returns a word the model does not expect.

// File: rtl/slink_pkg.sv
package slink_pkg;
   typedef logic [31:0] ptr_t;

   function automatic ptr_t to_gray(ptr_t b);
      return b ^ (b >> 1);
   endfunction
endpackage

// File: rtl/slink_store.sv
module slink_store #(
   parameter int ENTRY_W = 33,
   parameter int DEPTH   = 16,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic               wr_clk,
   input  logic               we,
   input  logic [AW-1:0]      waddr,
   input  logic [ENTRY_W-1:0] wentry,
   input  logic [AW-1:0]      raddr,
   output logic [ENTRY_W-1:0] rentry
);
   logic [ENTRY_W-1:0] cells [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) cells[waddr] <= wentry;
   end

   assign rentry = cells[raddr];
endmodule

// File: rtl/slink_sync.sv
module slink_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/slink_ptr.sv
module slink_ptr #(
   parameter int PW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [PW-1:0] bin,
   output logic [PW-1:0] gray
);
   import slink_pkg::*;

   logic [PW-1:0] bin_nx;
   assign bin_nx = bin + PW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bin  <= '0;
         gray <= '0;
      end else if (step) begin
         bin  <= bin_nx;
         gray <= PW'(to_gray(ptr_t'(bin_nx)));
      end
   end
endmodule

// File: rtl/stream_link_fifo.sv
module stream_link_fifo #(
   parameter int DATA_W      = 32,
   parameter int DEPTH       = 16,
   parameter bit ASYNC       = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_ctrl,
   output logic              full,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_ctrl,
   output logic              exists
);
   localparam int ADDR_W  = $clog2(DEPTH);
   localparam int PTR_W   = ADDR_W + 1;
   localparam int ENTRY_W = DATA_W + 1;

   if (DEPTH < 4 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("stream_link_fifo: DEPTH must be a power of two, at least 4");
   end
   if (ASYNC && SYNC_STAGES < 2) begin : g_bad_sync
      $error("stream_link_fifo: SYNC_STAGES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("stream_link_fifo: DATA_W must be positive");
   end

   logic [PTR_W-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
   logic [PTR_W-1:0] rd_gray_w, wr_gray_r;
   logic             wr_take, rd_take;
   logic [ENTRY_W-1:0] head;

   assign wr_take = wr_en && !full;
   assign rd_take = rd_en && exists;

   slink_ptr #(.PW(PTR_W)) u_wptr (
      .clk(wr_clk), .rst_n(wr_rst_n), .step(wr_take), .bin(wr_bin), .gray(wr_gray)
   );
   slink_ptr #(.PW(PTR_W)) u_rptr (
      .clk(rd_clk), .rst_n(rd_rst_n), .step(rd_take), .bin(rd_bin), .gray(rd_gray)
   );

   if (ASYNC) begin : g_async
      slink_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
         .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_w)
      );
      slink_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
         .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_r)
      );
   end else begin : g_common
      assign rd_gray_w = rd_gray;
      assign wr_gray_r = wr_gray;
   end

   assign full   = (wr_gray == {~rd_gray_w[PTR_W-1:PTR_W-2], rd_gray_w[PTR_W-3:0]});
   assign exists = (rd_gray != wr_gray_r);

   slink_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_store (
      .wr_clk(wr_clk),
      .we(wr_take),
      .waddr(wr_bin[ADDR_W-1:0]),
      .wentry({wr_ctrl, wr_data}),
      .raddr(rd_bin[ADDR_W-1:0]),
      .rentry(head)
   );

   assign rd_ctrl = head[DATA_W];
   assign rd_data = head[DATA_W-1:0];
endmodule

// File: rtl/stream_link_fifo_chk.sv
module stream_link_fifo_chk #(
   parameter int PW = 5,
   parameter int DW = 32
) (
   input logic          wr_clk,
   input logic          wr_rst_n,
   input logic          wr_en,
   input logic          full,
   input logic [PW-1:0] wr_gray,
   input logic          rd_clk,
   input logic          rd_rst_n,
   input logic          rd_en,
   input logic          exists,
   input logic [PW-1:0] rd_gray,
   input logic [DW-1:0] rd_data,
   input logic          rd_ctrl
);
   a_r5_no_overflow: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_en && full) |=> $stable(wr_gray));

   a_r6_no_underflow: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_en && !exists) |=> $stable(rd_gray));

   a_r7_wr_gray_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      $countones(wr_gray ^ $past(wr_gray)) <= 1);

   a_r7_rd_gray_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      $countones(rd_gray ^ $past(rd_gray)) <= 1);

   a_r3_head_hold: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (exists && !rd_en) |=> (exists && $stable({rd_ctrl, rd_data})));

   a_r8_wr_reset_clear: assert property (@(posedge wr_clk)
      !wr_rst_n |=> !full);

   a_r8_rd_reset_clear: assert property (@(posedge rd_clk)
      !rd_rst_n |=> !exists);
endmodule

bind stream_link_fifo stream_link_fifo_chk #(.PW(PTR_W), .DW(DATA_W)) u_chk (
   .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .full(full), .wr_gray(wr_gray),
   .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .exists(exists), .rd_gray(rd_gray),
   .rd_data(rd_data), .rd_ctrl(rd_ctrl)
);

// File: tb/stream_link_fifo_bench.sv
module stream_link_fifo_bench;
   localparam int CLK_PERIOD = 10;
   localparam int RD_PERIOD  = 14;
   localparam int DEPTH      = 16;

   logic wr_clk = 1'b0, rd_clk = 1'b0;
   always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
   always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

   logic        wr_rst_n = 1'b0, rd_rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_ctrl = 1'b0, rd_en = 1'b0;
   logic [31:0] wr_data = '0, rd_data;
   logic        rd_ctrl, full, exists;

   stream_link_fifo #(.DATA_W(32), .DEPTH(DEPTH), .ASYNC(1'b1)) u_stream_link_fifo (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_ctrl(wr_ctrl), .full(full), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
      .rd_en(rd_en), .rd_data(rd_data), .rd_ctrl(rd_ctrl), .exists(exists)
   );

   logic        s_rst_n = 1'b0, s_wr_en = 1'b0, s_wr_ctrl = 1'b0, s_rd_en = 1'b0;
   logic [31:0] s_wr_data = '0, s_rd_data;
   logic        s_rd_ctrl, s_full, s_exists;

   stream_link_fifo #(.DATA_W(32), .DEPTH(DEPTH), .ASYNC(1'b0)) u_stream_link_fifo_sync (
      .wr_clk(wr_clk), .wr_rst_n(s_rst_n), .wr_en(s_wr_en), .wr_data(s_wr_data),
      .wr_ctrl(s_wr_ctrl), .full(s_full), .rd_clk(wr_clk), .rd_rst_n(s_rst_n),
      .rd_en(s_rd_en), .rd_data(s_rd_data), .rd_ctrl(s_rd_ctrl), .exists(s_exists)
   );

   int checks = 0, failures = 0;
   logic [32:0] q[$];
   bit writer_done;

   task automatic chk(bit ok, string req, logic [32:0] act, logic [32:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int wr_prob(int i);
      return ((i / 64) % 2 == 0) ? 85 : 30;
   endfunction

   function automatic int rd_prob(int i);
      return ((i / 50) % 2 == 0) ? 35 : 90;
   endfunction

   task automatic push_try(logic [31:0] d, logic c);
      @(negedge wr_clk);
      wr_en = 1'b1; wr_data = d; wr_ctrl = c;
      if (!full) begin
         if (q.size() >= DEPTH) chk(1'b0, "R7 accepted write beyond depth", 33'(q.size()), 33'(DEPTH));
         q.push_back({c, d});
      end
   endtask

   task automatic writer(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge wr_clk);
         wr_en = (($urandom % 100) < wr_prob(i));
         wr_data = $urandom; wr_ctrl = 1'($urandom);
         if (wr_en && !full) begin
            if (q.size() >= DEPTH) chk(1'b0, "R7 accepted write beyond depth", 33'(q.size()), 33'(DEPTH));
            q.push_back({wr_ctrl, wr_data});
         end
      end
      @(negedge wr_clk); wr_en = 1'b0;
      writer_done = 1'b1;
   endtask

   task automatic reader(int limit, bit random_rd);
      for (int i = 0; i < limit; i++) begin
         @(negedge rd_clk);
         rd_en = random_rd ? (($urandom % 100) < rd_prob(i)) : 1'b1;
         if (exists) begin
            if (q.size() == 0) begin
               chk(1'b0, "R2 exists with empty queue", 33'(exists), 33'd0);
            end else begin
               chk({rd_ctrl, rd_data} == q[0], rd_en ? "R1 word order" : "R3 head shown",
                   {rd_ctrl, rd_data}, q[0]);
               if (rd_en) void'(q.pop_front());
            end
         end
         if (writer_done && q.size() == 0) break;
      end
      @(negedge rd_clk); rd_en = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge rd_clk);
      wr_rst_n = 1'b1; rd_rst_n = 1'b1; s_rst_n = 1'b1;
      @(negedge wr_clk);
      chk(!full,   "R8 full after reset",   33'(full),   33'd0);
      chk(!exists, "R8 exists after reset", 33'(exists), 33'd0);
      chk(!s_full && !s_exists, "R8 sync flags after reset", {s_full, s_exists}, 33'd0);

      // random traffic
      writer_done = 1'b0;
      fork
         writer(1500);
         reader(8000, 1'b1);
      join
      chk(q.size() == 0, "R1 all words delivered", 33'(q.size()), 33'd0);

      // fill to full, then ignored writes
      writer_done = 1'b0;
      for (int i = 0; i < DEPTH; i++) push_try(32'hA000_0000 + i, 1'(i));
      @(negedge wr_clk); wr_en = 1'b0;
      @(negedge wr_clk);
      chk(full, "R4 full after DEPTH writes", 33'(full), 33'd1);
      chk(q.size() == DEPTH, "R4 accepted count", 33'(q.size()), 33'(DEPTH));
      for (int i = 0; i < 3; i++) push_try(32'hDEAD_BEEF, 1'b1);
      @(negedge wr_clk); wr_en = 1'b0;
      chk(q.size() == DEPTH, "R5 writes while full ignored", 33'(q.size()), 33'(DEPTH));
      writer_done = 1'b1;
      repeat (4) @(negedge rd_clk);
      reader(200, 1'b0);
      repeat (8) @(negedge rd_clk);
      chk(!exists, "R5 no extra word after drain", 33'(exists), 33'd0);
      chk(q.size() == 0, "R5 drained count", 33'(q.size()), 33'd0);

      // read while empty
      @(negedge rd_clk); rd_en = 1'b1;
      repeat (3) @(negedge rd_clk);
      rd_en = 1'b0;
      push_try(32'h1234_5678, 1'b1);
      @(negedge wr_clk); wr_en = 1'b0;
      repeat (6) @(negedge rd_clk);
      chk(exists, "R6 exists after write", 33'(exists), 33'd1);
      chk({rd_ctrl, rd_data} == {1'b1, 32'h1234_5678}, "R6 empty reads ignored",
          {rd_ctrl, rd_data}, {1'b1, 32'h1234_5678});
      reader(20, 1'b0);
      repeat (2) @(negedge rd_clk);
      chk(!exists, "R2 exists low when empty", 33'(exists), 33'd0);

      // reset with data stored
      for (int i = 0; i < 3; i++) push_try(32'h5500_0000 + i, 1'b0);
      @(negedge wr_clk); wr_en = 1'b0;
      repeat (4) @(negedge rd_clk);
      wr_rst_n = 1'b0; rd_rst_n = 1'b0;
      repeat (2) @(negedge rd_clk);
      wr_rst_n = 1'b1; rd_rst_n = 1'b1;
      q.delete();
      repeat (4) @(negedge rd_clk);
      chk(!full && !exists, "R8 flags cleared by mid-run reset", {full, exists}, 33'd0);

      // synchronous variant: next-cycle visibility and one-entry collision
      @(negedge wr_clk);
      s_wr_en = 1'b1; s_wr_data = 32'hCAFE_0001; s_wr_ctrl = 1'b1;
      @(negedge wr_clk);
      s_wr_en = 1'b0;
      chk(s_exists, "R10 exists next cycle", 33'(s_exists), 33'd1);
      chk({s_rd_ctrl, s_rd_data} == {1'b1, 32'hCAFE_0001}, "R10 word visible",
          {s_rd_ctrl, s_rd_data}, {1'b1, 32'hCAFE_0001});
      s_wr_en = 1'b1; s_wr_data = 32'hCAFE_0002; s_wr_ctrl = 1'b0; s_rd_en = 1'b1;
      @(negedge wr_clk);
      s_wr_en = 1'b0; s_rd_en = 1'b0;
      chk(s_exists, "R9 one entry remains", 33'(s_exists), 33'd1);
      chk({s_rd_ctrl, s_rd_data} == {1'b0, 32'hCAFE_0002}, "R9 second word next",
          {s_rd_ctrl, s_rd_data}, {1'b0, 32'hCAFE_0002});
      s_rd_en = 1'b1;
      @(negedge wr_clk);
      s_rd_en = 1'b0;
      chk(!s_exists, "R9 empty after both read", 33'(s_exists), 33'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule